// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of 51 synchronous interrupt input levels into a 51-bit pending vector. It keeps one detection cell per source. At run time each cell follows its configuration bits and acts as one of five detectors:

- active-high level
- active-low level
- rising edge
- falling edge
- any edge

A level source's pending bit follows the input, one clock late. An edge source's pending bit latches when the edge is seen and stays set until the register interface clears it with a strobe.

The block owns the three configuration vectors: sensitivity, polarity and any-edge. Each has a fixed reset value. Each is written through one shared data port, with a separate write enable for the low 32 bits and for the upper 19 bits. The block also presents the vectors so that the surrounding register decode can read them. The block does not synchronise the pins, decode addresses or steer interrupts to processor lines.

Top module: `irq_trig_detect`

## Requirements
- R1: After reset, `raw_o` is all zeros and the vectors read back as `sense_o` = 0x1F07FFF8FFFF, `dual_o` = 0xF800070000 and `event_o` = 0x5F07FFF8FFFF. The previous-level store is also cleared.
- R2: A source whose sense bit is 1 is level-triggered. On each clock its raw bit takes the sampled input when its event bit is 1, and the inverted input when its event bit is 0. The raw bit therefore drops as soon as the active level goes away.
- R3: A source whose sense bit is 0 and whose dual bit is 0 is edge-triggered. With event bit 1 it sets its raw bit when the sample is 1 and the previous sample was 0. With event bit 0 it sets its raw bit when the sample is 0 and the previous sample was 1. The raw bit is set on the clock edge that captures the new sample.
- R4: A source whose sense bit is 0 and whose dual bit is 1 sets its raw bit on any difference between the current and the previous sample, whatever its event bit.
- R5: The raw bit of an edge source stays set until a 1 arrives on its bit of `edge_clr_i`. A 1 on `edge_clr_i` for a source whose sense bit is 1 has no effect.
- R6: When a new edge and a clear strobe hit the same source in the same cycle, the raw bit ends up set.
- R7: In `cfg_we` enables, bit 0 writes bits 0 to 31 and bit 1 writes bits 32 to 50, taking data from `cfg_wdata_i`. Bits not enabled keep their value. A written value is used from the next sample on.
- R8: Changing a source from level to edge sensing leaves a pending raw bit set.
- R9: The previous sample of every source is stored on every clock, in both modes. After a switch from level to edge mode, a steady input therefore raises no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 51 | Synchronous source levels |
| edge_clr_i | input | 51 | Per-source clear strobe for edge pending bits |
| cfg_wdata_i | input | 51 | Write data shared by the configuration vectors |
| sense_we_i | input | 2 | Sensitivity write enables: bit 0 is the low part, bit 1 the high part |
| dual_we_i | input | 2 | Any-edge write enables: bit 0 is the low part, bit 1 the high part |
| event_we_i | input | 2 | Polarity write enables: bit 0 is the low part, bit 1 the high part |
| raw_o | output | 51 | Raw pending vector |
| sense_o | output | 51 | Current sensitivity vector (1 = level) |
| dual_o | output | 51 | Current any-edge vector |
| event_o | output | 51 | Current polarity vector (1 = high or rising) |

## Verification
The directed cases each target one likely mistake:

- **Clear and edge in the same cycle.** A design that let the clear win would lose an interrupt.
- **Clear on a level source.** A design that let the clear reach it would drop a pending level that is still asserted.
- **Level-to-edge switch with a steady high input.** A design that stored the previous sample only in edge mode would see a false edge. A design that cleared pending bits on a mode change would lose the pending bit.
- **Half writes.** These catch a swapped or merged write enable, which would corrupt the untouched half.

Random stimulus over all five modes, with sparse clears and occasional configuration writes, catches any disagreement with the bench's own model of the next pending vector.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned SRC_N = 51;
  localparam int unsigned LO_W  = 32;

  localparam logic [63:0] SENSE_RST = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] DUAL_RST  = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] EVENT_RST = 64'h0000_5F07_FFF8_FFFF;

  typedef enum logic [2:0] {
    MODE_LVL_HI,
    MODE_LVL_LO,
    MODE_RISE,
    MODE_FALL,
    MODE_BOTH
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic sense, input logic evt, input logic dual);
    if (sense)     return evt ? MODE_LVL_HI : MODE_LVL_LO;
    else if (dual) return MODE_BOTH;
    else           return evt ? MODE_RISE : MODE_FALL;
  endfunction
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg #(
  parameter int unsigned W       = 51,
  parameter int unsigned LO_W    = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned HI_W = W - LO_W;

  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_q <= RST_VAL[LO_W-1:0];
    else if (we_i[0]) lo_q <= wdata_i[LO_W-1:0];
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hi_q <= RST_VAL[W-1:LO_W];
        else if (we_i[1]) hi_q <= wdata_i[W-1:LO_W];
      end
      assign q_o = {hi_q, lo_q};
    end else begin : g_lo_only
      assign q_o = lo_q;
    end
  endgenerate
endmodule

// File: rtl/trig_src_cell.sv
module trig_src_cell
  import irq_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  input  logic sense_i,
  input  logic event_i,
  input  logic dual_i,
  output logic raw_o
);
  logic       prev_q, raw_q, raw_d, hit;
  trig_mode_e mode;

  assign mode = decode_mode(sense_i, event_i, dual_i);

  always_comb begin
    hit = 1'b0;
    unique case (mode)
      MODE_RISE: hit = lvl_i & ~prev_q;
      MODE_FALL: hit = ~lvl_i & prev_q;
      MODE_BOTH: hit = lvl_i ^ prev_q;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_LVL_HI: raw_d = lvl_i;
      MODE_LVL_LO: raw_d = ~lvl_i;
      // new edge beats a clear in the same cycle
      default:     raw_d = hit | (raw_q & ~clr_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import irq_trig_pkg::*;
#(
  parameter int unsigned N  = SRC_N,
  parameter int unsigned LW = LO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] edge_clr_i,
  input  logic [N-1:0] cfg_wdata_i,
  input  logic [1:0]   sense_we_i,
  input  logic [1:0]   dual_we_i,
  input  logic [1:0]   event_we_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] sense_o,
  output logic [N-1:0] dual_o,
  output logic [N-1:0] event_o
);
  localparam logic [N-1:0] SENSE_INIT = SENSE_RST[N-1:0];
  localparam logic [N-1:0] DUAL_INIT  = DUAL_RST[N-1:0];
  localparam logic [N-1:0] EVENT_INIT = EVENT_RST[N-1:0];

  trig_cfg_reg #(.W(N), .LO_W(LW), .RST_VAL(SENSE_INIT)) u_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sense_we_i), .wdata_i(cfg_wdata_i), .q_o(sense_o));
  trig_cfg_reg #(.W(N), .LO_W(LW), .RST_VAL(DUAL_INIT)) u_dual (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dual_we_i), .wdata_i(cfg_wdata_i), .q_o(dual_o));
  trig_cfg_reg #(.W(N), .LO_W(LW), .RST_VAL(EVENT_INIT)) u_event (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(event_we_i), .wdata_i(cfg_wdata_i), .q_o(event_o));

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      trig_src_cell u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (level_i[i]),
        .clr_i  (edge_clr_i[i]),
        .sense_i(sense_o[i]),
        .event_i(event_o[i]),
        .dual_i (dual_o[i]),
        .raw_o  (raw_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/irq_trig_detect_chk.sv
module irq_trig_detect_chk #(
  parameter int unsigned N = 51
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] level_i,
  input logic [N-1:0] edge_clr_i,
  input logic [1:0]   sense_we_i,
  input logic [1:0]   dual_we_i,
  input logic [1:0]   event_we_i,
  input logic [N-1:0] raw_o,
  input logic [N-1:0] sense_o,
  input logic [N-1:0] dual_o,
  input logic [N-1:0] event_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_level_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0) |=> ((raw_o & $past(sense_o)) ==
                          ($past(sense_o) & ~($past(level_i) ^ $past(event_o)))));

  p_edge_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0) |=> (($past(raw_o) & ~$past(sense_o) & ~$past(edge_clr_i) & ~raw_o) == '0));

  p_edge_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |=> ((raw_o & ~$past(raw_o) & ~$past(sense_o) &
                           ~($past(level_i) ^ $past(level_i, 2))) == '0));

  p_sense_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_we_i == 2'b00) |=> $stable(sense_o));
  p_dual_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_we_i == 2'b00) |=> $stable(dual_o));
  p_event_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_we_i == 2'b00) |=> $stable(event_o));
endmodule

bind irq_trig_detect irq_trig_detect_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_i), .edge_clr_i(edge_clr_i),
  .sense_we_i(sense_we_i), .dual_we_i(dual_we_i), .event_we_i(event_we_i),
  .raw_o(raw_o), .sense_o(sense_o), .dual_o(dual_o), .event_o(event_o));

// File: tb/irq_trig_detect_test.sv
`timescale 1ns/1ps
module irq_trig_detect_test;
  localparam int N = 51;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] level_i = '0, edge_clr_i = '0, cfg_wdata_i = '0;
  logic [1:0]   sense_we_i = '0, dual_we_i = '0, event_we_i = '0;
  logic [N-1:0] raw_o, sense_o, dual_o, event_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [N-1:0] m_raw, m_prev, m_sense, m_dual, m_event;

  localparam logic [N-1:0] SENSE_EXP = 51'h1F07FFF8FFFF;
  localparam logic [N-1:0] DUAL_EXP  = 51'h00F800070000;
  localparam logic [N-1:0] EVENT_EXP = 51'h5F07FFF8FFFF;

  always #2.5 clk_i = ~clk_i;

  irq_trig_detect uut (.*);

  function automatic logic [N-1:0] next_raw(input logic [N-1:0] raw, prev, lvl, clr, sns, dul, evt);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (sns[i]) r[i] = evt[i] ? lvl[i] : ~lvl[i];
      else begin
        logic hit;
        if (dul[i])      hit = lvl[i] ^ prev[i];
        else if (evt[i]) hit = lvl[i] & ~prev[i];
        else             hit = ~lvl[i] & prev[i];
        r[i] = hit | (raw[i] & ~clr[i]);
      end
    end
    return r;
  endfunction

  function automatic logic [N-1:0] merge(input logic [N-1:0] old, wd, input logic [1:0] we);
    logic [N-1:0] r = old;
    if (we[0]) r[31:0] = wd[31:0];
    if (we[1]) r[N-1:32] = wd[N-1:32];
    return r;
  endfunction

  task automatic chk_vec(input string tag, input logic [N-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input int idx, input logic exp);
    total++;
    if (raw_o[idx] !== exp) begin
      bad++;
      $display("FAIL %s bit %0d act=%b exp=%b", tag, idx, raw_o[idx], exp);
    end
  endtask

  // drive at negedge, update model at posedge, compare at the following negedge
  task automatic step(input string tag, input logic [N-1:0] lvl, clr, wd,
                      input logic [1:0] swe, dwe, ewe);
    logic [N-1:0] nr;
    level_i = lvl; edge_clr_i = clr; cfg_wdata_i = wd;
    sense_we_i = swe; dual_we_i = dwe; event_we_i = ewe;
    nr = next_raw(m_raw, m_prev, lvl, clr, m_sense, m_dual, m_event);
    @(posedge clk_i);
    m_raw = nr; m_prev = lvl;
    m_sense = merge(m_sense, wd, swe);
    m_dual  = merge(m_dual, wd, dwe);
    m_event = merge(m_event, wd, ewe);
    @(negedge clk_i);
    chk_vec(tag, raw_o, m_raw);
    chk_vec("R7 cfg", {sense_o ^ m_sense} | {dual_o ^ m_dual} | {event_o ^ m_event}, '0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] z = '0;
    logic [N-1:0] b0 = 51'd1, b2 = 51'd4;
    void'($urandom(32'd1234));
    m_raw = '0; m_prev = '0;
    m_sense = SENSE_EXP; m_dual = DUAL_EXP; m_event = EVENT_EXP;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk_vec("R1 raw", raw_o, '0);
    chk_vec("R1 sense", sense_o, SENSE_EXP);
    chk_vec("R1 dual", dual_o, DUAL_EXP);
    chk_vec("R1 event", event_o, EVENT_EXP);

    // configure: bit0 level-high, bit1 level-low, bit2 rise, bit3 fall, bit4 both
    step("R7", z, z, 51'b00011, 2'b11, 2'b00, 2'b00);
    step("R7", z, z, 51'b00101, 2'b00, 2'b00, 2'b11);
    step("R7", z, z, 51'b10000, 2'b00, 2'b11, 2'b00);
    step("R5", z, '1, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R2 low-level", 1, 1'b1);
    chk_bit("R2 high-level", 0, 1'b0);
    step("R3", 51'b11111, z, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R2 high-level", 0, 1'b1);
    chk_bit("R2 low-level", 1, 1'b0);
    chk_bit("R3 rise", 2, 1'b1);
    chk_bit("R3 fall idle", 3, 1'b0);
    chk_bit("R4 both rise", 4, 1'b1);
    step("R3", z, z, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R3 fall", 3, 1'b1);
    chk_bit("R5 sticky", 2, 1'b1);
    step("R4", z, 51'b10000, z, 2'b00, 2'b00, 2'b00);
    step("R4", 51'b10000, z, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R4 rise", 4, 1'b1);
    step("R4", z, 51'b10000, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R4 fall beats clear", 4, 1'b1);
    step("R5", z, b2, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R5 cleared", 2, 1'b0);
    chk_bit("R5 other kept", 3, 1'b1);
    step("R5", b0, b0, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R5 clear ignored on level", 0, 1'b1);
    step("R6", b0 | b2, b2, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R6 edge beats clear", 2, 1'b1);
    step("R8", b0 | b2, z, z, 2'b11, 2'b00, 2'b00);
    chk_bit("R8 pending before switch", 0, 1'b1);
    step("R8", b0 | b2, z, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R8 pending kept", 0, 1'b1);
    step("R9", b0 | b2, b0, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R9 cleared", 0, 1'b0);
    step("R9", b0 | b2, z, z, 2'b00, 2'b00, 2'b00);
    chk_bit("R9 no false edge", 0, 1'b0);
    // R7 half writes
    step("R7", b0 | b2, z, '1, 2'b00, 2'b00, 2'b01);
    chk_vec("R7 low half", event_o, {m_event[N-1:32], 32'hFFFF_FFFF});
    step("R7", b0 | b2, z, z, 2'b00, 2'b00, 2'b10);
    chk_vec("R7 high half", event_o, {19'd0, 32'hFFFF_FFFF});

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic [63:0] rl, rc, rw;
      logic [1:0] s, d, e;
      rl = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) rl = {13'd0, level_i};
      rc = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      rw = {$urandom(), $urandom()};
      s = ($urandom_range(0, 15) == 0) ? 2'($urandom()) : 2'b00;
      d = ($urandom_range(0, 15) == 0) ? 2'($urandom()) : 2'b00;
      e = ($urandom_range(0, 15) == 0) ? 2'($urandom()) : 2'b00;
      step("R2 R3 R4 R5 R6 random", rl[N-1:0], rc[N-1:0], rw[N-1:0], s, d, e);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule